// File: doc/BRIEF.md
# Flash Standby Power Gate Controller

This controller decides when the steady-state supply of the on-chip flash array is switched off, and guards the array while it is off. Software sets a single standby bit through a small register bus. A write to that bit is accepted only when the instruction doing the write was fetched from RAM. The reason is that code running from flash cannot safely switch off the memory it is executing from.

While the bit is set, the controller watches every bus cycle. If a cycle targets flash, it raises a one-cycle standby-reset request and then drops the bit. Interrupt acknowledges also affect the bit. When the vectors live in flash, the acknowledge clears the bit so that the vector can be read. When the vectors live in RAM, the bit is left alone, but a vector fetch that still lands in flash raises the reset request.

The power-down output also depends on the CPU power mode. The idle, sleep and stop codes force the flash off whatever the bit holds. The run modes pass the bit straight through.

Top module: `flash_stby_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the standby bit reads 0, `stby_rst_req` is 0, and `flash_pwr_dn` is 0 in a run mode.
- R2: A write with `rb_wr`=1, `rb_addr`=0 and `fetch_in_ram`=1 loads `rb_wdata[0]` into the standby bit at the next edge. A read at address 0 returns the bit on bit 0, and bits 7..1 always read 0.
- R3: The same write with `fetch_in_ram`=0 is discarded, and the bit keeps its value.
- R4: Writes to any address other than 0 leave the bit unchanged, and reads of any address other than 0 return 0.
- R5: A cycle with `acc_valid`=1 and `acc_is_flash`=1 while the bit is 1 makes `stby_rst_req` high for exactly the next cycle. Accesses to RAM, and flash accesses while the bit is 0, raise nothing.
- R6: The cycle after `stby_rst_req` is high, the standby bit is 0.
- R7: `int_ack`=1 with `vec_sel_ram`=0 clears the bit at the next edge.
- R8: `int_ack`=1 with `vec_sel_ram`=1 leaves the bit unchanged.
- R9: `int_ack`=1 with `vec_sel_ram`=1 and `vec_addr_flash`=1 while the bit is 1 raises `stby_rst_req` in the next cycle.
- R10: `pwr_mode` codes 4..7 (IDLE0=4, IDLE1=5, IDLE2=6, sleep/stop=7) force `flash_pwr_dn`=1 whatever the bit holds.
- R11: `pwr_mode` codes 0..3 (NORMAL1, NORMAL2, SLOW1, SLOW2) make `flash_pwr_dn` equal to the standby bit.
- R12: If a clear from an interrupt acknowledge and an accepted write happen in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_wr | input | 1 | Register write strobe |
| rb_addr | input | 4 | Register address |
| rb_wdata | input | 8 | Register write data |
| rb_rdata | output | 8 | Register read data for `rb_addr` |
| fetch_in_ram | input | 1 | Current instruction was fetched from RAM |
| acc_valid | input | 1 | A bus cycle is in progress |
| acc_is_flash | input | 1 | The bus cycle targets the flash region |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| vec_sel_ram | input | 1 | 1 when the interrupt vectors are located in RAM |
| vec_addr_flash | input | 1 | The vector fetch address falls in flash |
| pwr_mode | input | 3 | CPU power mode code |
| flash_pwr_dn | output | 1 | Flash steady-state current cut enable |
| stby_rst_req | output | 1 | One-cycle standby-reset request |

## Verification
Some rules are checked by the assertions on every cycle:
- writes issued from flash leave the bit alone;
- the clear beats a write arriving in the same cycle;
- a flash access or a flash vector fetch under standby yields exactly one request pulse, and that pulse drops the bit;
- the sleep-class modes always force power-down.

Other rules need the bench's scenarios to be shown:
- the value actually loaded by a write;
- the masking of the unused read bits;
- the silence of other addresses;
- a whole sequence of one bit passing through writes, interrupts, resets and mode changes.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_NORMAL1 = 3'd0,
    PM_NORMAL2 = 3'd1,
    PM_SLOW1   = 3'd2,
    PM_SLOW2   = 3'd3,
    PM_IDLE0   = 3'd4,
    PM_IDLE1   = 3'd5,
    PM_IDLE2   = 3'd6,
    PM_SLEEP   = 3'd7
  } pwr_mode_e;

  // lowest code at which the flash is cut regardless of the standby bit
  localparam logic [MODE_W-1:0] PM_FORCE_MIN = PM_IDLE0;

endpackage

// File: rtl/fsc_rst_sync.sv
module fsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fsc_regif.sv
module fsc_regif #(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int          BIT_POS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              from_ram,
  input  logic              clr,
  output logic [DATA_W-1:0] rdata,
  output logic              stby
);

  logic sel;
  logic wr_ok;
  logic stby_d;
  logic stby_en;

  always_comb begin
    sel     = (addr == REG_ADDR);
    wr_ok   = wr & sel & from_ram;
    stby_en = clr | wr_ok;
    stby_d  = clr ? 1'b0 : wdata[BIT_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stby <= 1'b0;
    else if (stby_en) stby <= stby_d;
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_rd
    if (g == BIT_POS) begin : g_live
      assign rdata[g] = sel & stby;
    end else begin : g_zero
      assign rdata[g] = 1'b0;
    end
  end

  // R3
  flash_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr & sel & !from_ram & !clr) |=> $stable(stby));

  // R12
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr & wr & sel & from_ram) |=> !stby);

  // R2
  ram_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr & sel & from_ram & !clr) |=> (stby == $past(wdata[BIT_POS])));

endmodule

// File: rtl/fsc_guard.sv
module fsc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic stby,
  input  logic acc_valid,
  input  logic acc_flash,
  input  logic irq_ack,
  input  logic vec_ram,
  input  logic vec_flash,
  output logic rst_req,
  output logic clr_req
);

  logic acc_hit;
  logic vec_hit;
  logic req_d;

  always_comb begin
    acc_hit = acc_valid & acc_flash & stby;
    vec_hit = irq_ack & vec_ram & vec_flash & stby;
    req_d   = (acc_hit | vec_hit) & ~rst_req;
    clr_req = rst_req | (irq_ack & ~vec_ram);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= req_d;
  end

  // R5
  flash_touch_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid & acc_flash & stby & !rst_req) |=> rst_req);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R9
  vector_in_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack & vec_ram & vec_flash & stby & !rst_req) |=> rst_req);

endmodule

// File: rtl/fsc_pwr.sv
module fsc_pwr #(
  parameter int                MODE_W    = 3,
  parameter logic [MODE_W-1:0] FORCE_MIN = 3'd4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              stby,
  output logic              pwr_dn
);

  logic forced;

  always_comb begin
    forced = (mode >= FORCE_MIN);
    pwr_dn = forced | stby;
  end

endmodule

// File: rtl/flash_stby_ctrl.sv
module flash_stby_ctrl
  import fsc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 0,
  parameter int BIT_POS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_wr,
  input  logic [ADDR_W-1:0] rb_addr,
  input  logic [DATA_W-1:0] rb_wdata,
  output logic [DATA_W-1:0] rb_rdata,
  input  logic              fetch_in_ram,
  input  logic              acc_valid,
  input  logic              acc_is_flash,
  input  logic              int_ack,
  input  logic              vec_sel_ram,
  input  logic              vec_addr_flash,
  input  logic [2:0]        pwr_mode,
  output logic              flash_pwr_dn,
  output logic              stby_rst_req
);

  localparam logic [ADDR_W-1:0] REG_ADDR_L = ADDR_W'(REG_ADDR);

  logic rst_n_s;
  logic stby;
  logic clr_req;

  fsc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fsc_regif #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR_L),
    .BIT_POS  (BIT_POS)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr       (rb_wr),
    .addr     (rb_addr),
    .wdata    (rb_wdata),
    .from_ram (fetch_in_ram),
    .clr      (clr_req),
    .rdata    (rb_rdata),
    .stby     (stby)
  );

  fsc_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .stby      (stby),
    .acc_valid (acc_valid),
    .acc_flash (acc_is_flash),
    .irq_ack   (int_ack),
    .vec_ram   (vec_sel_ram),
    .vec_flash (vec_addr_flash),
    .rst_req   (stby_rst_req),
    .clr_req   (clr_req)
  );

  fsc_pwr #(
    .MODE_W    (MODE_W),
    .FORCE_MIN (PM_FORCE_MIN)
  ) u_pwr (
    .mode   (pwr_mode),
    .stby   (stby),
    .pwr_dn (flash_pwr_dn)
  );

  // R6
  pulse_drops_bit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    stby_rst_req |=> !stby);

  // R7
  flash_vector_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (int_ack & !vec_sel_ram) |=> !stby);

  // R8
  ram_vector_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (int_ack & vec_sel_ram & !stby_rst_req & !(rb_wr & fetch_in_ram & (rb_addr == REG_ADDR_L)))
      |=> (stby == $past(stby)));

  // R10
  sleep_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pwr_mode[2] |-> flash_pwr_dn);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_s |-> (!stby_rst_req && !stby));

endmodule

// File: tb/flash_stby_ctrl_test.sv
`timescale 1ns/1ps
module flash_stby_ctrl_test;

  typedef struct packed {
    logic       wr;
    logic       ram;
    logic [3:0] addr;
    logic [7:0] wd;
    logic       av;
    logic       af;
    logic       ia;
    logic       vr;
    logic       vf;
    logic [2:0] md;
    logic       eb;
    logic       er;
    logic       ep;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    // wr    ram   addr  wdata  av    af    ia    vr    vf    mode  bit   rst   pd    req
    '{1'b1, 1'b1, 4'd0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 set
    '{1'b0, 1'b1, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 RAM access
    '{1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 flash write
    '{1'b1, 1'b1, 4'd3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 other addr
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd8},  // R8
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 4'd11}, // R11 SLOW1
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 hit
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 drop
    '{1'b1, 1'b1, 4'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 all ones
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b1, 4'd0, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{1'b1, 1'b1, 4'd0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 4'd9},  // R9
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 IDLE0
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 sleep
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 SLOW2
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 bit clear
    '{1'b1, 1'b1, 4'd0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 4'd10}, // R10 IDLE2
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 4'd11}  // R11 NORMAL2
  };

  logic       clk;
  logic       rst_n;
  logic       rb_wr;
  logic [3:0] rb_addr;
  logic [7:0] rb_wdata;
  logic [7:0] rb_rdata;
  logic       fetch_in_ram;
  logic       acc_valid;
  logic       acc_is_flash;
  logic       int_ack;
  logic       vec_sel_ram;
  logic       vec_addr_flash;
  logic [2:0] pwr_mode;
  logic       flash_pwr_dn;
  logic       stby_rst_req;

  int checks;
  int fails;
  bit done;

  flash_stby_ctrl uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rb_wr          (rb_wr),
    .rb_addr        (rb_addr),
    .rb_wdata       (rb_wdata),
    .rb_rdata       (rb_rdata),
    .fetch_in_ram   (fetch_in_ram),
    .acc_valid      (acc_valid),
    .acc_is_flash   (acc_is_flash),
    .int_ack        (int_ack),
    .vec_sel_ram    (vec_sel_ram),
    .vec_addr_flash (vec_addr_flash),
    .pwr_mode       (pwr_mode),
    .flash_pwr_dn   (flash_pwr_dn),
    .stby_rst_req   (stby_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    rb_wr = 1'b0; rb_addr = 4'd0; rb_wdata = 8'h00; fetch_in_ram = 1'b0;
    acc_valid = 1'b0; acc_is_flash = 1'b0; int_ack = 1'b0;
    vec_sel_ram = 1'b0; vec_addr_flash = 1'b0; pwr_mode = 3'd0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    fails = 0;
    done = 1'b0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: state held in reset
    check("R1 rdata", rb_rdata, 8'h00);
    check("R1 rst", {7'b0, stby_rst_req}, 8'h00);
    check("R1 pd", {7'b0, flash_pwr_dn}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", {6'b0, flash_pwr_dn, stby_rst_req}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rb_wr = TBL[i].wr; fetch_in_ram = TBL[i].ram; rb_addr = TBL[i].addr;
      rb_wdata = TBL[i].wd; acc_valid = TBL[i].av; acc_is_flash = TBL[i].af;
      int_ack = TBL[i].ia; vec_sel_ram = TBL[i].vr; vec_addr_flash = TBL[i].vf;
      pwr_mode = TBL[i].md;
      @(posedge clk);
      #1;
      begin
        string tag;
        tag = $sformatf("R%0d vec%0d", TBL[i].rq, i);
        check({tag, " rst"}, {7'b0, stby_rst_req}, {7'b0, TBL[i].er});
        check({tag, " pd"}, {7'b0, flash_pwr_dn}, {7'b0, TBL[i].ep});
        check({tag, " rdata"}, rb_rdata,
              (TBL[i].addr == 4'd0) ? {7'b0, TBL[i].eb} : 8'h00);
      end
    end

    // R2 and R4: readback masking and other addresses with bit set
    @(negedge clk);
    idle_inputs();
    rb_addr = 4'd0;
    #1;
    check("R2 readback", rb_rdata, 8'h01);
    rb_addr = 4'd5;
    #1;
    check("R4 other read", rb_rdata, 8'h00);
    rb_addr = 4'd15;
    #1;
    check("R4 top read", rb_rdata, 8'h00);

    // R3: flash-fetched write of 0 while bit is 1, observed in run mode
    @(negedge clk);
    rb_wr = 1'b1; rb_addr = 4'd0; rb_wdata = 8'h00; fetch_in_ram = 1'b0;
    @(posedge clk);
    #1;
    check("R3 discard", {7'b0, flash_pwr_dn}, 8'h01);

    // R1: asynchronous reset mid-run drops the bit
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check("R1 async clear", rb_rdata, 8'h00);
    check("R1 async pd", {7'b0, flash_pwr_dn}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 stays clear", rb_rdata, 8'h00);

    finish_run();
  end

endmodule